// File: doc/BRIEF.md
# Convolutional Byte Deinterleaver

The block restores the original byte order of a terrestrial digital TV stream that was spread out in time by a convolutional interleaver. It is placed between the trellis decoder and the Reed-Solomon decoder. Each accepted input byte goes to one of 52 branches in strict rotation. Every branch is a delay line whose length falls by a fixed step from the first branch to the last. The sum of the interleaver delay and the deinterleaver delay is therefore the same for every byte. All delay lines share one on-chip memory. Each branch owns a circular region of that memory, addressed by its own pointer.

A field-start marker, taken with a valid byte, resets the rotation to the first branch and restarts the fill count. The output stays invalid until the longest branch has been fully refreshed. After that, a start flag marks the first byte of each 207-byte codeword for the Reed-Solomon decoder. Cycles where the input valid is low freeze the whole block.

Top module: `byte_deinterleaver`

## Requirements
- R1: Each cycle with `in_valid` high accepts one byte onto the current branch. The branch index then advances by one and wraps from 51 to 0. After reset the first byte goes to branch 0.
- R2: A byte accepted on branch k comes out on the output at the visit to branch k that happens (51-k)*4 visits later. The last branch, 51, has no delay.
- R3: Outputs are registered. The byte of an accepted input, with its `out_valid` and `out_sop`, appears one clock cycle after the input is taken.
- R4: A cycle with `in_valid` low does not advance the branch and does not touch the memory or the counters. In the next cycle `out_valid` and `out_sop` are low and `out_data` keeps its value.
- R5: A byte taken with `in_valid` and `in_sync` both high is placed on branch 0, whatever branch was current. Rotation continues from branch 1.
- R6: After reset, and after each accepted sync byte (which counts as byte 0), the first 10608 accepted bytes (52*51*4) give `out_valid` low.
- R7: `out_sop` is high with the first valid output after the fill, and with every 207th valid output after it. It is never high without `out_valid`.
- R8: While `rst_n` is low, `out_valid` and `out_sop` are low. Branch, fill count and codeword count return to zero.
- R9: `in_sync` has no effect in a cycle where `in_valid` is low. The fill count, rotation and codeword position are all kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte qualifier |
| in_sync | input | 1 | Field start marker, taken only with `in_valid` |
| in_data | input | 8 | Interleaved byte from the trellis decoder |
| out_valid | output | 1 | Output byte qualifier |
| out_sop | output | 1 | First byte of a 207-byte codeword |
| out_data | output | 8 | Deinterleaved byte to the Reed-Solomon decoder |

## Verification
A branch index that is off by one, or a pointer that wraps one slot early, shows up as wrong bytes in the very first valid output of the affected branch. The bench catches this 10609 accepted bytes after a sync. A wrong fill or codeword count moves the rising edge of `out_valid` or the `out_sop` pulses, and the first such edge exposes it. A sync that fails to force branch 0, or a sync wrongly taken while idle, shifts the branch-to-data mapping for the rest of the stream. Every later valid byte then mismatches.

// File: rtl/dlv_pkg.sv
package dlv_pkg;

   // Delay, counted in branch visits, of branch k
   function automatic int dlv_delay(input int k, input int nb, input int step);
      return (nb - 1 - k) * step;
   endfunction

   // First memory word of branch k: the summed delays of the lower branches
   function automatic int dlv_base(input int k, input int nb, input int step);
      int s;
      s = 0;
      for (int j = 0; j < k; j++) s += (nb - 1 - j) * step;
      return s;
   endfunction

endpackage

// File: rtl/dlv_commutator.sv
module dlv_commutator #(
   parameter int NB     = 52,
   parameter int CW_LEN = 207,
   parameter int FILL   = 10608,
   localparam int BW    = $clog2(NB),
   localparam int CNTW  = $clog2(FILL + 1),
   localparam int SEGW  = $clog2(CW_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sync,
   output logic [BW-1:0] cur_branch,
   output logic          out_valid,
   output logic          out_sop
);

   logic [BW-1:0]   br_q;
   logic [CNTW-1:0] cnt_q, cnt_cur;
   logic [SEGW-1:0] seg_q, seg_cur;
   logic            primed;

   always_comb begin
      cur_branch = in_sync ? '0 : br_q;
      cnt_cur    = in_sync ? '0 : cnt_q;
      seg_cur    = in_sync ? '0 : seg_q;
      primed     = (cnt_cur == CNTW'(FILL));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         br_q      <= '0;
         cnt_q     <= '0;
         seg_q     <= '0;
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
      end else begin
         out_valid <= in_valid && primed;
         out_sop   <= in_valid && primed && (seg_cur == '0);
         if (in_valid) begin
            br_q <= (cur_branch == BW'(NB - 1)) ? '0 : cur_branch + 1'b1;
            if (!primed) cnt_q <= cnt_cur + 1'b1;
            if (primed)
               seg_q <= (seg_cur == SEGW'(CW_LEN - 1)) ? '0 : seg_cur + 1'b1;
            else
               seg_q <= '0;
         end
      end
   end

   AST_BRANCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      br_q < BW'(NB)); // R1
   AST_SYNC_BRANCH0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sync) |=> (br_q == BW'(1))); // R5
   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(br_q) && !out_valid)); // R4
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R3
   AST_FILL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sync) |=> !out_valid); // R6
   AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync && !in_valid) |=> ($stable(cnt_q) && $stable(seg_q))); // R9

endmodule

// File: rtl/dlv_ptr_bank.sv
module dlv_ptr_bank
   import dlv_pkg::*;
#(
   parameter int NB   = 52,
   parameter int STEP = 4,
   parameter int AW   = 13,
   parameter int PW   = 8,
   localparam int BW  = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [BW-1:0] cur_branch,
   output logic [AW-1:0] addr,
   output logic          bypass
);

   logic [AW-1:0] base_w [NB];
   logic [PW-1:0] ptr_w  [NB];
   logic          byp_w  [NB];

   for (genvar k = 0; k < NB; k++) begin : g_branch
      localparam int D    = dlv_delay(k, NB, STEP);
      localparam int BASE = dlv_base(k, NB, STEP);
      assign base_w[k] = AW'(BASE);
      assign byp_w[k]  = (D == 0);
      if (D == 0) begin : g_pass
         assign ptr_w[k] = '0;
      end else begin : g_line
         logic [PW-1:0] p_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               p_q <= '0;
            else if (adv && (cur_branch == BW'(k)))
               p_q <= (p_q == PW'(D - 1)) ? '0 : p_q + 1'b1;
         end
         assign ptr_w[k] = p_q;
         AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            p_q < PW'(D)); // R2
      end
   end

   always_comb begin
      addr   = base_w[cur_branch] + AW'(ptr_w[cur_branch]);
      bypass = byp_w[cur_branch];
   end

endmodule

// File: rtl/dlv_store.sv
module dlv_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 5304,
   parameter int AW    = 13
) (
   input  logic          clk,
   input  logic          we,
   input  logic          bypass,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] mem [DEPTH];

   // Read-before-write: the slot yields its old byte and takes the new one
   always_ff @(posedge clk) begin
      if (we) begin
         if (bypass) begin
            rdata <= wdata;
         end else begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
         end
      end
   end

endmodule

// File: rtl/byte_deinterleaver.sv
module byte_deinterleaver
   import dlv_pkg::*;
#(
   parameter int DW     = 8,
   parameter int NB     = 52,
   parameter int STEP   = 4,
   parameter int CW_LEN = 207
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sync,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   output logic          out_sop,
   output logic [DW-1:0] out_data
);

   localparam int MAXD  = (NB - 1) * STEP;
   localparam int DEPTH = STEP * NB * (NB - 1) / 2;
   localparam int FILL  = MAXD * NB;
   localparam int BW    = $clog2(NB);
   localparam int PW    = (MAXD > 1) ? $clog2(MAXD) : 1;
   localparam int AW    = $clog2(DEPTH + 1);

   if (NB < 2) begin : g_bad_nb
      $error("byte_deinterleaver: NB must be at least 2");
   end
   if (STEP < 1) begin : g_bad_step
      $error("byte_deinterleaver: STEP must be at least 1");
   end
   if (CW_LEN < 2) begin : g_bad_cw
      $error("byte_deinterleaver: CW_LEN must be at least 2");
   end

   logic [BW-1:0] cur_branch;
   logic [AW-1:0] addr;
   logic          bypass;

   dlv_commutator #(.NB(NB), .CW_LEN(CW_LEN), .FILL(FILL)) i_comm (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sync    (in_sync),
      .cur_branch (cur_branch),
      .out_valid  (out_valid),
      .out_sop    (out_sop)
   );

   dlv_ptr_bank #(.NB(NB), .STEP(STEP), .AW(AW), .PW(PW)) i_ptrs (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (in_valid),
      .cur_branch (cur_branch),
      .addr       (addr),
      .bypass     (bypass)
   );

   dlv_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_store (
      .clk    (clk),
      .we     (in_valid),
      .bypass (bypass),
      .addr   (addr),
      .wdata  (in_data),
      .rdata  (out_data)
   );

   AST_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid); // R7
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data)); // R4

endmodule

// File: tb/test_byte_deinterleaver.sv
`timescale 1ns/1ps
module test_byte_deinterleaver;

   localparam int NB   = 52;
   localparam int STEP = 4;
   localparam int CWL  = 207;
   localparam int FILL = NB * (NB - 1) * STEP;
   localparam int NROW = 4;
   // Each row: sync on first byte, number of valid bytes, stall period (0 = none)
   localparam int ROWS [NROW][3] = '{
      '{1, 12000, 5},
      '{0,  1500, 0},
      '{1,   300, 3},
      '{0, 11000, 9}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sync = 1'b0;
   logic [7:0] in_data = '0;
   logic       out_valid, out_sop;
   logic [7:0] out_data;

   always #2 clk = ~clk;

   byte_deinterleaver i_byte_deinterleaver (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sync(in_sync),
      .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
      .out_data(out_data)
   );

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // Reference model state
   logic [7:0] data_mem [65536];
   int vis_idx [NB][2048];
   int vis_cnt [NB];
   int g = 0, m_br = 0, m_cnt = 0, m_seg = 0;
   bit e_valid = 0, e_sop = 0, known = 0;
   logic [7:0] e_data = '0;
   string dtag = "R2";

   task automatic chk(input bit ok, input string req, input int act, input int exp,
                      input string what);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_br = 0; m_cnt = 0; m_seg = 0; known = 0; e_valid = 0; e_sop = 0;
      for (int k = 0; k < NB; k++) vis_cnt[k] = 0;
   endtask

   // Drive one cycle at a falling edge, compare at the next falling edge
   task automatic step(input bit v, input bit s);
      string vtag;
      bit primed;
      in_valid = v; in_sync = s;
      if (v) begin
         int k, vc, d;
         if (s) begin m_br = 0; m_cnt = 0; m_seg = 0; end
         k = m_br;
         primed = (m_cnt >= FILL);
         data_mem[g] = 8'((g * 73) + (g / 251));
         in_data = data_mem[g];
         e_valid = primed;
         e_sop = primed && (m_seg == 0);
         if (primed) m_seg = (m_seg + 1) % CWL; else m_cnt++;
         vc = vis_cnt[k];
         d = (NB - 1 - k) * STEP;
         vis_idx[k][vc] = g;
         if (primed && vc >= d) e_data = data_mem[vis_idx[k][vc - d]];
         known = primed;
         vis_cnt[k] = vc + 1;
         m_br = (m_br + 1) % NB;
         g++;
         vtag = primed ? "R3" : "R6";
      end else begin
         in_data = 8'hA5;
         e_valid = 0; e_sop = 0;
         vtag = "R4";
      end
      @(negedge clk);
      chk(out_valid === e_valid, vtag, int'(out_valid), int'(e_valid), "out_valid");
      if (out_sop !== e_sop || e_sop)
         chk(out_sop === e_sop, "R7", int'(out_sop), int'(e_sop), "out_sop");
      if (known)
         chk(out_data === e_data, v ? dtag : "R4", int'(out_data), int'(e_data),
             "out_data");
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 0; in_sync = 0;
      model_reset();
      @(negedge clk);
      chk(out_valid === 1'b0, "R8", int'(out_valid), 0, "out_valid in reset");
      chk(out_sop === 1'b0, "R8", int'(out_sop), 0, "out_sop in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid === 1'b0, "R8", int'(out_valid), 0, "out_valid after reset");
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // Table walk
      for (int r = 0; r < NROW; r++) begin
         dtag = (r == 0) ? "R1" : ((r == 1) ? "R2" : "R5");
         for (int i = 0; i < ROWS[r][1]; i++) begin
            if (ROWS[r][2] != 0 && (i % ROWS[r][2]) == ROWS[r][2] - 1) step(0, 0);
            step(1, (ROWS[r][0] != 0) && (i == 0));
         end
      end
      // R9: sync without valid is ignored, output stays primed
      dtag = "R9";
      step(0, 1);
      step(1, 0);
      chk(out_valid === 1'b1, "R9", int'(out_valid), 1, "valid after idle sync");
      for (int i = 0; i < 300; i++) step(1, 0);
      // R8: reset mid-stream, then fill restarts without any sync
      do_reset();
      dtag = "R6";
      for (int i = 0; i < FILL + 500; i++) step(1, 0);
      done = 1'b1;
      in_valid = 0;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule